// File: doc/BRIEF.md
# Two-Bank SDRAM Command Timing Checker

This block watches the command stream going to a synchronous DRAM with two banks and judges every command against the bank-level timing rules. On each rising clock edge it samples a 3-bit command code and a 1-bit bank select. It keeps an idle/active state per bank and two saturating cycle counters per bank: one counting cycles since the bank's last activate and one counting cycles since its last precharge. From these it decides, in the same cycle, whether the command on its inputs is legal.

A legal command updates the bank state at the next edge. An illegal command leaves the state and counters unchanged and sets one or more sticky violation flags, one flag per rule. A separate flag reports that an active bank has been left open too long. All timing limits are elaboration-time cycle counts.

The command inputs are a monitored bus, not a stream. The checker cannot stall them and has no valid/ready handshake. A command is present in every cycle, and code 0 is the idle cycle. No back-pressure exists.

Top module: `sdram_bank_timing_chk`

## Requirements
- R1: While reset is low, and in the first cycle after it, both banks are idle (`bank_active_o` = 00) and `viol_o` = 0. The precharge recovery of both banks counts as already satisfied, so an activate in the first cycle after reset is legal.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, READ-auto-precharge=4, WRITE-auto-precharge=5, PRECHARGE=6; code 7 acts as NOP. An accepted ACTIVE sets bit `bank_i` of `bank_active_o` at the next edge. An accepted PRECHARGE, code 4 or code 5 to an active bank clears that bit at the next edge. Codes 2 and 3 leave the state unchanged.
- R3: An ACTIVE issued n cycles after that bank's accepted precharge is illegal when n < T_RP and sets `viol_o[0]`.
- R4: An ACTIVE issued n cycles after the last accepted ACTIVE to the other bank is illegal when n < T_RRD and sets `viol_o[1]`.
- R5: A PRECHARGE to an active bank issued n cycles after its ACTIVE is illegal when n < T_RAS_MIN and sets `viol_o[2]`.
- R6: A bank that is still active T_RAS_MAX+1 cycles after its ACTIVE sets `viol_o[3]`, which is visible one cycle later. A precharge at n ≤ T_RAS_MAX avoids it.
- R7: A command with code 2, 3, 4 or 5 issued n cycles after the bank's ACTIVE is illegal when n < T_RCD and sets `viol_o[4]`.
- R8: An ACTIVE to an active bank, or a code 2 to 5 to an idle bank, is illegal and sets `viol_o[5]`.
- R9: An illegal command changes neither the bank state nor the bank's counters.
- R10: A PRECHARGE to an idle bank is legal and has no effect; in particular, it does not restart that bank's T_RP count.
- R11: Violation flags stay set until `clr_i` is high at a clock edge, which clears them. A violation detected in the clearing cycle is kept.
- R12: `cmd_ok_o` reflects the legality of the present inputs in the same cycle. Flags and state change at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 3 | Command code (see R2) |
| bank_i | input | 1 | Bank addressed by the command |
| clr_i | input | 1 | Synchronous clear of the violation flags |
| bank_active_o | output | 2 | Per-bank state, 1 = active |
| cmd_ok_o | output | 1 | Present command is legal |
| viol_o | output | 6 | Sticky flags: 0 precharge recovery, 1 cross-bank activate spacing, 2 early precharge, 3 open too long, 4 early access, 5 state error |

## Verification
`cmd_ok_o` is combinational. It is sampled 1 ns after inputs change on the falling edge, before the rising edge that captures them. Bank state and flags are registered once and are sampled 1 ns after that rising edge. The same command therefore has its legality checked in its own cycle and its effect checked in the next. The open-too-long flag is due in the cycle after the bank's counter passes T_RAS_MAX, and the bench checks both the cycle just before that point and the cycle of it.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_RDA = 3'd4,
    CMD_WRA = 3'd5,
    CMD_PRE = 3'd6,
    CMD_RSV = 3'd7
  } sbt_cmd_e;

  localparam int unsigned V_RP     = 0;
  localparam int unsigned V_RRD    = 1;
  localparam int unsigned V_RASMIN = 2;
  localparam int unsigned V_RASMAX = 3;
  localparam int unsigned V_RCD    = 4;
  localparam int unsigned V_STATE  = 5;
  localparam int unsigned V_NUM    = 6;
  localparam int unsigned N_BANKS  = 2;
endpackage

// File: rtl/sbt_sat_cnt.sv
module sbt_sat_cnt #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] SAT = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  // Reset to saturation: any earlier event counts as long past.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             value_o <= SAT;
    else if (restart_i)     value_o <= ONE;
    else if (value_o != SAT) value_o <= value_o + ONE;
  end
endmodule

// File: rtl/sbt_bank.sv
module sbt_bank #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic         close_i,
  output logic         active_o,
  output logic [W-1:0] since_act_o,
  output logic [W-1:0] since_pre_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_o <= 1'b0;
    else if (open_i)  active_o <= 1'b1;
    else if (close_i) active_o <= 1'b0;
  end

  sbt_sat_cnt #(.W(W)) u_act_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(open_i),
    .value_o  (since_act_o)
  );

  sbt_sat_cnt #(.W(W)) u_pre_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(close_i),
    .value_o  (since_pre_o)
  );
endmodule

// File: rtl/sbt_rules.sv
module sbt_rules
  import sbt_pkg::*;
#(
  parameter int unsigned W         = 5,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_RAS_MIN = 6,
  parameter int unsigned T_RAS_MAX = 20,
  parameter int unsigned T_RCD     = 3
) (
  input  logic [2:0]                 cmd_i,
  input  logic                       bank_i,
  input  logic [N_BANKS-1:0]         active_i,
  input  logic [N_BANKS-1:0][W-1:0]  since_act_i,
  input  logic [N_BANKS-1:0][W-1:0]  since_pre_i,
  output logic [V_NUM-1:0]           viol_o,
  output logic                       ok_o,
  output logic [N_BANKS-1:0]         open_o,
  output logic [N_BANKS-1:0]         close_o
);
  localparam logic [W-1:0] RP_C     = W'(T_RP);
  localparam logic [W-1:0] RRD_C    = W'(T_RRD);
  localparam logic [W-1:0] RASMIN_C = W'(T_RAS_MIN);
  localparam logic [W-1:0] RASMAX_C = W'(T_RAS_MAX);
  localparam logic [W-1:0] RCD_C    = W'(T_RCD);

  sbt_cmd_e cmd;
  logic     sel, oth;
  logic     is_act, is_rw, is_auto, is_pre;
  logic     sel_act;
  logic [N_BANKS-1:0] late;

  assign cmd     = sbt_cmd_e'(cmd_i);
  assign sel     = bank_i;
  assign oth     = ~bank_i;
  assign sel_act = active_i[sel];
  assign is_act  = (cmd == CMD_ACT);
  assign is_auto = (cmd == CMD_RDA) || (cmd == CMD_WRA);
  assign is_rw   = (cmd == CMD_RD) || (cmd == CMD_WR) || is_auto;
  assign is_pre  = (cmd == CMD_PRE);

  // Open-too-long detection per bank.
  for (genvar b = 0; b < N_BANKS; b++) begin : g_late
    assign late[b] = active_i[b] && (since_act_i[b] > RASMAX_C);
  end

  always_comb begin
    viol_o           = '0;
    viol_o[V_STATE]  = (is_act && sel_act) || (is_rw && !sel_act);
    viol_o[V_RP]     = is_act && !sel_act && (since_pre_i[sel] < RP_C);
    viol_o[V_RRD]    = is_act && !sel_act && (since_act_i[oth] < RRD_C);
    viol_o[V_RCD]    = is_rw && sel_act && (since_act_i[sel] < RCD_C);
    viol_o[V_RASMIN] = is_pre && sel_act && (since_act_i[sel] < RASMIN_C);
    viol_o[V_RASMAX] = |late;
  end

  // The open-too-long flag is about state, not about the present command.
  assign ok_o = !(viol_o[V_STATE] | viol_o[V_RP] | viol_o[V_RRD] |
                  viol_o[V_RCD] | viol_o[V_RASMIN]);

  for (genvar b = 0; b < N_BANKS; b++) begin : g_accept
    assign open_o[b]  = ok_o && is_act && (sel == b[0]);
    assign close_o[b] = ok_o && (is_pre || is_auto) && (sel == b[0]) && active_i[b];
  end
endmodule

// File: rtl/sdram_bank_timing_chk.sv
module sdram_bank_timing_chk
  import sbt_pkg::*;
#(
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_RAS_MIN = 6,
  parameter int unsigned T_RAS_MAX = 20,
  parameter int unsigned T_RCD     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic             bank_i,
  input  logic             clr_i,
  output logic [1:0]       bank_active_o,
  output logic             cmd_ok_o,
  output logic [V_NUM-1:0] viol_o
);
  localparam int unsigned M1    = (T_RP > T_RRD) ? T_RP : T_RRD;
  localparam int unsigned M2    = (T_RAS_MIN > T_RCD) ? T_RAS_MIN : T_RCD;
  localparam int unsigned M3    = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXT  = (M3 > T_RAS_MAX) ? M3 : T_RAS_MAX;
  localparam int unsigned CNT_W = $clog2(MAXT + 2);

  logic [N_BANKS-1:0]             active;
  logic [N_BANKS-1:0][CNT_W-1:0]  since_act;
  logic [N_BANKS-1:0][CNT_W-1:0]  since_pre;
  logic [N_BANKS-1:0]             open_b, close_b;
  logic [V_NUM-1:0]               viol_now;
  logic [V_NUM-1:0]               viol_q;
  logic                           ok;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    sbt_bank #(.W(CNT_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_i     (open_b[b]),
      .close_i    (close_b[b]),
      .active_o   (active[b]),
      .since_act_o(since_act[b]),
      .since_pre_o(since_pre[b])
    );
  end

  sbt_rules #(
    .W        (CNT_W),
    .T_RP     (T_RP),
    .T_RRD    (T_RRD),
    .T_RAS_MIN(T_RAS_MIN),
    .T_RAS_MAX(T_RAS_MAX),
    .T_RCD    (T_RCD)
  ) u_rules (
    .cmd_i      (cmd_i),
    .bank_i     (bank_i),
    .active_i   (active),
    .since_act_i(since_act),
    .since_pre_i(since_pre),
    .viol_o     (viol_now),
    .ok_o       (ok),
    .open_o     (open_b),
    .close_o    (close_b)
  );

  // Clear first, then merge this cycle's findings so none is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= '0;
    else        viol_q <= (clr_i ? '0 : viol_q) | viol_now;
  end

  assign bank_active_o = active;
  assign cmd_ok_o      = ok;
  assign viol_o        = viol_q;
endmodule

// File: rtl/sbt_chk.sv
module sbt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_i,
  input logic       bank_i,
  input logic       clr_i,
  input logic [1:0] bank_active_o,
  input logic       cmd_ok_o,
  input logic [5:0] viol_o
);
  a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok_o && cmd_i == 3'd1) |=> bank_active_o[$past(bank_i)]);

  a_r2_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok_o && (cmd_i == 3'd6 || cmd_i == 3'd4 || cmd_i == 3'd5) && bank_active_o[bank_i])
      |=> !bank_active_o[$past(bank_i)]);

  a_r8_act_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd1 && bank_active_o[bank_i]) |-> !cmd_ok_o);

  a_r8_access_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_i >= 3'd2) && (cmd_i <= 3'd5) && !bank_active_o[bank_i]) |-> !cmd_ok_o);

  a_r9_illegal_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok_o |=> $stable(bank_active_o));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  a_r12_illegal_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ok_o |=> (viol_o != 6'd0));
endmodule

bind sdram_bank_timing_chk sbt_chk u_sbt_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_i        (cmd_i),
  .bank_i       (bank_i),
  .clr_i        (clr_i),
  .bank_active_o(bank_active_o),
  .cmd_ok_o     (cmd_ok_o),
  .viol_o       (viol_o)
);

// File: tb/test_sdram_bank_timing_chk.sv
`timescale 1ns/1ps
module test_sdram_bank_timing_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic       bank = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] act_o;
  logic       ok_o;
  logic [5:0] viol_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  sdram_bank_timing_chk #(
    .T_RP(3), .T_RRD(2), .T_RAS_MIN(6), .T_RAS_MAX(20), .T_RCD(3)
  ) i_sdram_bank_timing_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .clr_i(clr),
    .bank_active_o(act_o), .cmd_ok_o(ok_o), .viol_o(viol_o)
  );

  // {cmd[3], bank, clr, exp_ok, exp_active_after[2], exp_viol_after[6]}
  localparam int NV = 20;
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 1'b1, 2'b00, 6'h00}, // 0  NOP (R1)
    {3'd2, 1'b0, 1'b0, 1'b0, 2'b00, 6'h20}, // 1  read idle bank (R8)
    {3'd0, 1'b0, 1'b1, 1'b1, 2'b00, 6'h00}, // 2  clear (R11)
    {3'd1, 1'b0, 1'b0, 1'b1, 2'b01, 6'h00}, // 3  ACT b0 right after reset (R1, R2)
    {3'd1, 1'b1, 1'b0, 1'b0, 2'b01, 6'h02}, // 4  ACT b1 at 1 < tRRD (R4, R9)
    {3'd2, 1'b0, 1'b0, 1'b0, 2'b01, 6'h12}, // 5  READ b0 at 2 < tRCD (R7)
    {3'd1, 1'b1, 1'b0, 1'b1, 2'b11, 6'h12}, // 6  ACT b1 at 3 >= tRRD (R4)
    {3'd2, 1'b0, 1'b0, 1'b1, 2'b11, 6'h12}, // 7  READ b0 at 4 >= tRCD (R7, R2)
    {3'd6, 1'b0, 1'b0, 1'b0, 2'b11, 6'h16}, // 8  PRE b0 at 5 < tRAS min (R5)
    {3'd6, 1'b0, 1'b0, 1'b1, 2'b10, 6'h16}, // 9  PRE b0 at 6 (R5, R2)
    {3'd1, 1'b0, 1'b0, 1'b0, 2'b10, 6'h17}, // 10 ACT b0 at 1 < tRP (R3)
    {3'd1, 1'b1, 1'b0, 1'b0, 2'b10, 6'h37}, // 11 ACT active b1 (R8)
    {3'd0, 1'b0, 1'b1, 1'b1, 2'b10, 6'h00}, // 12 clear (R11)
    {3'd1, 1'b0, 1'b0, 1'b1, 2'b11, 6'h00}, // 13 ACT b0 at 4 >= tRP (R3)
    {3'd5, 1'b1, 1'b0, 1'b1, 2'b01, 6'h00}, // 14 WRITE+auto b1 closes (R2)
    {3'd6, 1'b1, 1'b0, 1'b1, 2'b01, 6'h00}, // 15 PRE idle b1, no effect (R10)
    {3'd0, 1'b0, 1'b0, 1'b1, 2'b01, 6'h00}, // 16 NOP
    {3'd1, 1'b1, 1'b0, 1'b1, 2'b11, 6'h00}, // 17 ACT b1 3 after WRA (R10, R3)
    {3'd3, 1'b1, 1'b0, 1'b0, 2'b11, 6'h10}, // 18 WRITE b1 at 1 < tRCD (R7, R9)
    {3'd4, 1'b0, 1'b0, 1'b1, 2'b10, 6'h10}  // 19 READ+auto b0 closes (R2)
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic b, input logic cl);
    @(negedge clk);
    cmd = c; bank = b; clr = cl;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 active in reset", {6'd0, act_o}, 8'h00);
    chk("R1 flags in reset", {2'd0, viol_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][13:11], VEC[i][10], VEC[i][9]);
      chk($sformatf("vector %0d cmd_ok", i), {7'd0, ok_o}, {7'd0, VEC[i][8]});
      tick();
      chk($sformatf("vector %0d active", i), {6'd0, act_o}, {6'd0, VEC[i][7:6]});
      chk($sformatf("vector %0d flags", i), {2'd0, viol_o}, {2'd0, VEC[i][5:0]});
    end

    // R6: bank1 opened three cycles ago; clear, then run to the limit.
    drive(3'd0, 1'b0, 1'b1);
    tick();
    chk("R11 clear", {2'd0, viol_o}, 8'h00);
    for (int k = 0; k < 17; k++) begin
      drive(3'd0, 1'b0, 1'b0);
      tick();
    end
    chk("R6 at tRAS max, no flag yet", {2'd0, viol_o}, 8'h00);
    drive(3'd0, 1'b0, 1'b0);
    tick();
    chk("R6 open too long flagged", {2'd0, viol_o}, 8'h08);
    chk("R6 bank stays active", {6'd0, act_o}, 8'h02);

    // R11: violation in the clearing cycle survives.
    drive(3'd2, 1'b0, 1'b1);
    chk("R8 read idle bank0 illegal", {7'd0, ok_o}, 8'h00);
    tick();
    chk("R11 new flag kept over clear", {2'd0, viol_o}, 8'h28);

    drive(3'd6, 1'b1, 1'b0);
    chk("R12 late precharge legal", {7'd0, ok_o}, 8'h01);
    tick();
    chk("R2 precharge closes bank1", {6'd0, act_o}, 8'h00);
    drive(3'd0, 1'b0, 1'b1);
    tick();
    chk("R11 final clear", {2'd0, viol_o}, 8'h00);

    // R7: auto-precharge form also obeys tRCD
    drive(3'd1, 1'b0, 1'b0);
    tick();
    drive(3'd4, 1'b0, 1'b0);
    chk("R7 auto read too early", {7'd0, ok_o}, 8'h00);
    tick();
    chk("R9 bank0 still active", {6'd0, act_o}, 8'h01);

    // R1: asynchronous reset returns to idle
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset active", {6'd0, act_o}, 8'h00);
    chk("R1 mid-run reset flags", {2'd0, viol_o}, 8'h00);

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule